// File: doc/BRIEF.md
# I2C Master Command Engine

This block is a single-master I2C controller. Software-side logic hands it command words. Each word holds a 7-bit target address and five flags: start, read, write, write-multiple and stop. Any mix of flags may share one word. Inside a word the engine always runs the same sequence. It first issues a start, or a repeated start when it already owns the bus. It then sends the address byte. Next comes the read or write transfer, and the stop comes last.

Write bytes come in on a valid/ready byte stream that carries a last marker. A plain write sends one byte. A write-multiple keeps sending bytes until it has sent the one marked last. Each byte read from a slave leaves on an output byte with a single-cycle valid strobe. The engine ACKs a read byte unless the same command also asks for a stop, in which case it NACKs.

Both bus lines are open-drain. Each has an output value that is tied to 0 and a separate output enable. Bit timing comes from a prescale input that gives the length of a quarter bit period in system clocks.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset both output enables are low and busy, bus_ctrl, bus_active and miss_ack are low. cmd_ready is high.
- R2: Whenever a start is issued for a command that has a transfer flag, the next byte on the bus is {cmd_addr, rw}, sent MSB first. rw is 1 for a read and 0 for a write.
- R3: A write command sends exactly one byte from the write stream. A write-multiple command sends bytes until it has sent the byte whose wr_last is 1. Every byte goes MSB first.
- R4: A read command takes in one byte and puts it on rd_data with rd_valid high for one cycle. The engine ACKs the byte (drives SDA low in the ninth slot) unless the same command has stop set, in which case it NACKs.
- R5: Within one command the order is start, then the address and transfer, then the stop. After the stop both lines are released and bus_ctrl is low.
- R6: A command with both read and write set is accepted but ignored. Busy stays low and no start appears on the bus.
- R7: miss_ack goes high when SDA is seen high in the acknowledge slot of a byte the engine sent. It stays high until miss_ack_clr is pulsed.
- R8: The quarter bit period is prescale clock cycles, and a prescale of 0 counts as 1. So every SCL high phase lasts 2*prescale cycles.
- R9: A start flag while the engine already owns the bus makes a repeated start, with no stop before it.
- R10: Lines are only pulled low through their enables, and scl_o and sda_o stay 0. Inside a data or acknowledge slot SDA does not change while SCL is high.
- R11: busy is high from command acceptance until the command finishes. bus_active reflects start and stop conditions seen on the lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low reset |
| prescale | input | PRE_W | quarter bit period in clocks |
| cmd_valid | input | 1 | command word offered |
| cmd_ready | output | 1 | engine idle, takes a command |
| cmd_addr | input | 7 | target address |
| cmd_start | input | 1 | issue start or repeated start |
| cmd_read | input | 1 | read one byte |
| cmd_write | input | 1 | write one byte |
| cmd_wrmulti | input | 1 | write bytes until last |
| cmd_stop | input | 1 | issue stop at the end |
| wr_data | input | 8 | write byte |
| wr_last | input | 1 | marks final byte of a multi-byte write |
| wr_valid | input | 1 | write byte offered |
| wr_ready | output | 1 | write byte taken |
| rd_data | output | 8 | received byte |
| rd_valid | output | 1 | one-cycle strobe for rd_data |
| scl_i | input | 1 | SCL line level |
| scl_o | output | 1 | SCL output value (always 0) |
| scl_oe | output | 1 | pulls SCL low when high |
| sda_i | input | 1 | SDA line level |
| sda_o | output | 1 | SDA output value (always 0) |
| sda_oe | output | 1 | pulls SDA low when high |
| busy | output | 1 | command in progress |
| bus_ctrl | output | 1 | engine owns the bus |
| bus_active | output | 1 | bus between start and stop |
| miss_ack | output | 1 | sticky missed acknowledge |
| miss_ack_clr | input | 1 | clears miss_ack |

## Verification
The bench builds the block with the default 16-bit prescale width. At run time it changes the prescale input between 0, 1, 2 and 5. This exercises the zero-as-one rule and lets it compare SCL high-phase lengths of 2, 4 and 10 cycles. The small values also keep each byte short, so the bench can reach in a short run: multi-byte writes, ACK/NACK read chains, repeated starts, address NACKs and the ignored read-plus-write word.

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] prescale,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [6:0]       cmd_addr,
  input  logic             cmd_start,
  input  logic             cmd_read,
  input  logic             cmd_write,
  input  logic             cmd_wrmulti,
  input  logic             cmd_stop,
  input  logic [7:0]       wr_data,
  input  logic             wr_last,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             scl_i,
  output logic             scl_o,
  output logic             scl_oe,
  input  logic             sda_i,
  output logic             sda_o,
  output logic             sda_oe,
  output logic             busy,
  output logic             bus_ctrl,
  output logic             bus_active,
  output logic             miss_ack,
  input  logic             miss_ack_clr
);

  typedef enum logic [2:0] {S_IDLE, S_NEXT, S_START, S_BYTE, S_STOP} st_t;

  st_t              st;
  logic             p_st, p_addr, p_rd, p_wr, p_wm, p_sp;
  logic [6:0]       addr_q;
  logic             rw_q, tx, ack_out, owned, miss, rd_v, act;
  logic [7:0]       shreg;
  logic [3:0]       bitn;
  logic [1:0]       q;
  logic [PRE_W-1:0] cnt;
  logic             scl_q, sda_q;
  logic             scl_low, sda_low, bit_rel;

  wire [PRE_W-1:0] presc_m1 = (prescale == '0) ? '0 : prescale - PRE_W'(1);
  wire tick     = (cnt == presc_m1);
  wire slot_end = tick && (q == 2'd3);
  wire xfer     = cmd_read | cmd_write | cmd_wrmulti;
  wire need_st  = cmd_start | (xfer & ~owned);

  assign cmd_ready  = (st == S_IDLE);
  assign wr_ready   = (st == S_NEXT) && !p_st && !p_addr && (p_wr || p_wm);
  assign rd_data    = shreg;
  assign rd_valid   = rd_v;
  assign busy       = (st != S_IDLE);
  assign bus_ctrl   = owned;
  assign bus_active = act;
  assign miss_ack   = miss;
  assign scl_o      = 1'b0;
  assign sda_o      = 1'b0;
  assign scl_oe     = scl_low;
  assign sda_oe     = sda_low;

  assign bit_rel = tx ? ((bitn == 4'd8) ? 1'b1 : shreg[7])
                      : ((bitn == 4'd8) ? ~ack_out : 1'b1);

  always_comb begin
    case (st)
      S_START: begin
        scl_low = ((q == 2'd0) && owned) || (q == 2'd3);
        sda_low = q[1];
      end
      S_BYTE: begin
        scl_low = (q == 2'd0) || (q == 2'd3);
        sda_low = ~bit_rel;
      end
      S_STOP: begin
        scl_low = (q == 2'd0);
        sda_low = ~q[1];
      end
      default: begin
        scl_low = owned;
        sda_low = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      q   <= 2'd0;
    end else if (st == S_IDLE || st == S_NEXT) begin
      cnt <= '0;
      q   <= 2'd0;
    end else if (tick) begin
      cnt <= '0;
      q   <= q + 2'd1;
    end else begin
      cnt <= cnt + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      act   <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (scl_i && scl_q && sda_q && !sda_i) act <= 1'b1;
      if (scl_i && scl_q && !sda_q && sda_i) act <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {p_st, p_addr, p_rd, p_wr, p_wm, p_sp} <= '0;
      addr_q <= '0;
      rw_q <= 1'b0;
      tx <= 1'b0;
      ack_out <= 1'b0;
      owned <= 1'b0;
      miss <= 1'b0;
      rd_v <= 1'b0;
      shreg <= '0;
      bitn <= '0;
    end else begin
      rd_v <= 1'b0;
      if (miss_ack_clr) miss <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid && !(cmd_read && cmd_write)) begin
          p_st   <= need_st;
          p_addr <= need_st & xfer;
          p_rd   <= cmd_read;
          p_wr   <= cmd_write;
          p_wm   <= cmd_wrmulti;
          p_sp   <= cmd_stop;
          addr_q <= cmd_addr;
          rw_q   <= cmd_read;
          st     <= S_NEXT;
        end
        S_NEXT: begin
          bitn <= '0;
          if (p_st) begin
            p_st <= 1'b0;
            st   <= S_START;
          end else if (p_addr) begin
            p_addr <= 1'b0;
            shreg  <= {addr_q, rw_q};
            tx     <= 1'b1;
            st     <= S_BYTE;
          end else if (p_wr || p_wm) begin
            if (wr_valid) begin
              shreg <= wr_data;
              tx    <= 1'b1;
              st    <= S_BYTE;
              if (p_wr) p_wr <= 1'b0;
              else if (wr_last) p_wm <= 1'b0;
            end
          end else if (p_rd) begin
            p_rd    <= 1'b0;
            tx      <= 1'b0;
            ack_out <= ~p_sp;
            st      <= S_BYTE;
          end else if (p_sp) begin
            p_sp <= 1'b0;
            if (owned) st <= S_STOP;
          end else begin
            st <= S_IDLE;
          end
        end
        S_START: if (slot_end) begin
          owned <= 1'b1;
          st    <= S_NEXT;
        end
        S_BYTE: begin
          if (tick && q == 2'd1) begin
            if (bitn != 4'd8) begin
              if (!tx) shreg <= {shreg[6:0], sda_i};
            end else if (tx && sda_i) begin
              miss <= 1'b1;
            end
          end
          if (slot_end) begin
            bitn <= bitn + 4'd1;
            if (tx && bitn != 4'd8) shreg <= {shreg[6:0], 1'b0};
            if (bitn == 4'd8) begin
              st <= S_NEXT;
              if (!tx) rd_v <= 1'b1;
            end
          end
        end
        S_STOP: if (slot_end) begin
          owned <= 1'b0;
          st    <= S_NEXT;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r10_sda_held_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BYTE && q == 2'd2) |-> $stable(sda_oe));

  a_r6_both_dirs_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cmd_valid && cmd_read && cmd_write) |=> (st == S_IDLE));

  a_r7_miss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && !miss_ack_clr) |=> miss);

  a_r4_rd_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_v |=> !rd_v);

  a_r5_stop_frees_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP && slot_end) |=> (!owned && !scl_oe && !sda_oe));

  a_r10_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe || sda_oe) |-> (!scl_o && !sda_o));

endmodule

// File: tb/i2c_cmd_master_bench.sv
module i2c_cmd_master_bench;
  localparam int PRE_W = 16;
  localparam logic [6:0] SLV = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [PRE_W-1:0] prescale = 16'd2;
  logic cmd_valid = 0, cmd_start = 0, cmd_read = 0, cmd_write = 0, cmd_wrmulti = 0, cmd_stop = 0;
  logic [6:0] cmd_addr = '0;
  logic cmd_ready;
  logic [7:0] wr_data;
  logic wr_last, wr_valid, wr_ready;
  logic [7:0] rd_data;
  logic rd_valid;
  logic scl_o, scl_oe, sda_o, sda_oe;
  logic busy, bus_ctrl, bus_active, miss_ack;
  logic miss_ack_clr = 0;
  logic s_pull = 0;

  wire scl_line = !scl_oe;
  wire sda_line = !sda_oe && !s_pull;

  i2c_cmd_master #(.PRE_W(PRE_W)) u_i2c_cmd_master (
    .clk(clk), .rst_n(rst_n), .prescale(prescale),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_start(cmd_start), .cmd_read(cmd_read), .cmd_write(cmd_write),
    .cmd_wrmulti(cmd_wrmulti), .cmd_stop(cmd_stop),
    .wr_data(wr_data), .wr_last(wr_last), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .scl_i(scl_line), .scl_o(scl_o), .scl_oe(scl_oe),
    .sda_i(sda_line), .sda_o(sda_o), .sda_oe(sda_oe),
    .busy(busy), .bus_ctrl(bus_ctrl), .bus_active(bus_active),
    .miss_ack(miss_ack), .miss_ack_clr(miss_ack_clr));

  int total = 0, bad = 0;
  logic [7:0] exp_bus[$];
  logic [7:0] exp_rd[$];
  logic [8:0] wr_q[$];
  int exp_rcnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // write stream feeder
  logic hs = 0;
  int popped = 0;
  always @(posedge clk) hs <= wr_valid && wr_ready;
  always @(negedge clk) begin
    if (hs) begin void'(wr_q.pop_front()); popped++; end
    wr_valid = (wr_q.size() > 0);
    {wr_last, wr_data} = (wr_q.size() > 0) ? wr_q[0] : 9'h0;
  end

  // read monitor
  always @(negedge clk) if (rst_n && rd_valid) begin
    if (exp_rd.size() == 0) chk(0, "R4 unexpected read byte", rd_data, 0);
    else begin
      logic [7:0] e;
      e = exp_rd.pop_front();
      chk(rd_data == e, "R4 read byte", rd_data, e);
    end
  end

  // line watchers
  int starts = 0, stops = 0, hcnt = 0, hw = 0;
  bit busy_seen = 0, act_seen = 0, drove_high = 0;
  always @(negedge clk) begin
    busy_seen |= busy;
    act_seen  |= bus_active;
    if (scl_o || sda_o) drove_high = 1;
    if (scl_line) hcnt++;
    else begin
      if (hcnt > 0) hw = hcnt;
      hcnt = 0;
    end
  end

  // slave model and bus-byte scoreboard monitor
  logic pscl = 1, psda = 1, in_addr = 0, rmode = 0, sel = 0, mack = 0;
  int rc = 0, rcnt = 0;
  logic [7:0] sh = 0, rb = 0;
  always @(negedge clk) if (rst_n) begin
    if (scl_line && pscl && psda && !sda_line) begin
      starts++; rc = 0; in_addr = 1; s_pull = 0;
    end
    if (scl_line && pscl && !psda && sda_line) begin
      stops++; rc = 0; in_addr = 0; rmode = 0; s_pull = 0;
    end
    if (scl_line && !pscl) begin
      if (rc < 8) sh = {sh[6:0], sda_line};
      else if (rc == 8 && rmode && !in_addr) mack = !sda_line;
      rc++;
    end
    if (!scl_line && pscl) begin
      if (rc == 8) begin
        if (in_addr || !rmode) begin
          if (exp_bus.size() == 0) chk(0, "R2 unexpected bus byte", sh, 0);
          else begin
            logic [7:0] e;
            e = exp_bus.pop_front();
            chk(sh == e, "R2/R3 bus byte", sh, e);
          end
          if (in_addr) begin sel = (sh[7:1] == SLV); rmode = sh[0]; end
          s_pull = sel;
        end else s_pull = 0;
      end else if (rc == 9) begin
        rc = 0; s_pull = 0;
        if (in_addr) begin
          in_addr = 0;
          if (sel && rmode) begin rb = 8'h5A ^ 8'(rcnt); rcnt++; s_pull = !rb[7]; end
        end else if (rmode && mack && sel) begin
          rb = 8'h5A ^ 8'(rcnt); rcnt++; s_pull = !rb[7];
        end
      end else if (rc >= 1 && rc <= 7 && rmode && !in_addr && sel) begin
        s_pull = !rb[7-rc];
      end
    end
    pscl = scl_line; psda = sda_line;
  end

  task automatic send_cmd(input logic [6:0] a, input bit st, input bit rd, input bit wr,
                          input bit wm, input bit sp);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_addr = a; cmd_start = st; cmd_read = rd; cmd_write = wr; cmd_wrmulti = wm; cmd_stop = sp;
    cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_read();
    exp_rd.push_back(8'h5A ^ 8'(exp_rcnt));
    exp_rcnt++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0, p0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
    chk(!busy && !bus_ctrl && !bus_active && !miss_ack, "R1 status low",
        {busy, bus_ctrl, bus_active, miss_ack}, 0);
    chk(cmd_ready, "R1 cmd_ready", cmd_ready, 1);

    // R2 R3 R5 R11: single write with start and stop, prescale 2
    busy_seen = 0; act_seen = 0;
    wr_q.push_back({1'b0, 8'hC3});
    exp_bus.push_back({SLV, 1'b0}); exp_bus.push_back(8'hC3);
    send_cmd(SLV, 1, 0, 1, 0, 1);
    chk(exp_bus.size() == 0, "R3 write byte seen", exp_bus.size(), 0);
    chk(busy_seen && act_seen, "R11 busy and bus_active seen", {busy_seen, act_seen}, 3);
    chk(!bus_ctrl && !bus_active && !scl_oe && !sda_oe, "R5 bus freed after stop",
        {bus_ctrl, bus_active, scl_oe, sda_oe}, 0);
    chk(hw == 4, "R8 high phase prescale 2", hw, 4);
    chk(!miss_ack, "R7 no miss on acked write", miss_ack, 0);

    // R3 write-multiple until last, prescale 1
    prescale = 16'd1;
    popped = 0;
    wr_q.push_back({1'b0, 8'h01}); wr_q.push_back({1'b0, 8'h80}); wr_q.push_back({1'b1, 8'h7E});
    wr_q.push_back({1'b0, 8'hEE});
    exp_bus.push_back({SLV, 1'b0});
    exp_bus.push_back(8'h01); exp_bus.push_back(8'h80); exp_bus.push_back(8'h7E);
    send_cmd(SLV, 1, 0, 0, 1, 1);
    chk(exp_bus.size() == 0, "R3 multi bytes seen", exp_bus.size(), 0);
    chk(popped == 3, "R3 stops at last byte", popped, 3);
    chk(hw == 2, "R8 high phase prescale 1", hw, 2);
    void'(wr_q.pop_front());

    // R4 read with stop: NACK
    prescale = 16'd0;
    exp_bus.push_back({SLV, 1'b1});
    expect_read();
    mack = 1;
    send_cmd(SLV, 1, 1, 0, 0, 1);
    chk(exp_rd.size() == 0, "R4 read delivered", exp_rd.size(), 0);
    chk(mack == 0, "R4 NACK before stop", mack, 0);
    chk(hw == 2, "R8 prescale 0 as 1", hw, 2);

    // R4 R11: read with ACK, bus kept, then read with stop
    prescale = 16'd2;
    exp_bus.push_back({SLV, 1'b1});
    expect_read();
    send_cmd(SLV, 1, 1, 0, 0, 0);
    chk(mack == 1, "R4 ACK without stop", mack, 1);
    chk(bus_ctrl && bus_active, "R11 bus held after no-stop read", {bus_ctrl, bus_active}, 3);
    s0 = starts;
    expect_read();
    send_cmd(SLV, 0, 1, 0, 0, 1);
    chk(mack == 0, "R4 NACK on last read", mack, 0);
    chk(starts == s0, "R5 no start without start flag", starts, s0);
    chk(exp_rd.size() == 0, "R4 both reads delivered", exp_rd.size(), 0);
    chk(!bus_active, "R11 bus_active drops at stop", bus_active, 0);

    // R9 repeated start: write no stop, then start+read+stop
    prescale = 16'd5;
    s0 = starts; p0 = stops;
    wr_q.push_back({1'b0, 8'h3C});
    exp_bus.push_back({SLV, 1'b0}); exp_bus.push_back(8'h3C);
    send_cmd(SLV, 1, 0, 1, 0, 0);
    exp_bus.push_back({SLV, 1'b1});
    expect_read();
    send_cmd(SLV, 1, 1, 0, 0, 1);
    chk(starts == s0 + 2, "R9 two starts", starts, s0 + 2);
    chk(stops == p0 + 1, "R9 single stop", stops, p0 + 1);
    chk(exp_bus.size() == 0 && exp_rd.size() == 0, "R9 bytes after repeated start",
        exp_bus.size() + exp_rd.size(), 0);
    chk(hw == 10, "R8 high phase prescale 5", hw, 10);

    // R6 ignored read+write
    prescale = 16'd1;
    s0 = starts; busy_seen = 0;
    send_cmd(SLV, 1, 1, 1, 0, 1);
    repeat (40) @(negedge clk);
    chk(!busy_seen, "R6 stays idle", busy_seen, 0);
    chk(starts == s0 && !bus_active, "R6 no bus activity", starts, s0);
    chk(cmd_ready, "R6 command consumed", cmd_ready, 1);

    // R7 missed ack sticky and clear
    wr_q.push_back({1'b0, 8'h55});
    exp_bus.push_back({7'h11, 1'b0}); exp_bus.push_back(8'h55);
    send_cmd(7'h11, 1, 0, 1, 0, 1);
    chk(miss_ack, "R7 miss set", miss_ack, 1);
    repeat (20) @(negedge clk);
    chk(miss_ack, "R7 miss sticky", miss_ack, 1);
    miss_ack_clr = 1;
    @(negedge clk);
    miss_ack_clr = 0;
    @(negedge clk);
    chk(!miss_ack, "R7 miss cleared", miss_ack, 0);

    chk(!drove_high, "R10 output values stay 0", drove_high, 0);
    chk(exp_bus.size() == 0, "R2 scoreboard drained", exp_bus.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule